// File: doc/BRIEF.md
# DDR Secure Region Address Filter

This block classifies every memory transaction address against a small table of programmable secure windows. Software defines up to eight windows on the DDR address space, each measured in whole megabytes with an inclusive upper bound. A ninth, implicit window covers every address that none of the enabled windows claims. Every window carries its own secure flag. A global pass-through switch can turn the whole filter off.

A transaction is presented as an address, a non-secure attribute and a valid strobe. One clock later the block returns an allow/deny verdict and the index of the window that decided it. A non-secure master touching a secure window is refused, and secure masters always pass. Configuration goes through a 32-bit register file. In every write, the upper halfword of the data enables the matching bit of the lower halfword, so individual control bits can be flipped without a read-modify-write.

Top module: `ddr_secure_filter`

## Requirements
- R1: After reset every register index reads 0, except index 21, which reads 0x0000_8000 (pass-through on). dec_valid, dec_allow and dec_rgn are 0.
- R2: A write updates bit k of the lower halfword (k in 0..15) only when cfg_wdata[16+k] is 1. All other bits keep their value.
- R3: Window n (0..7) uses register 6+2n and register 7+2n. Register 6+2n holds the start megabyte in bits [11:0], the secure flag in bit 14 and the enable in bit 15. Register 7+2n holds the inclusive end megabyte in bits [11:0]. Index 21 also holds the catch-all secure flag in bit 13 and the pass-through switch in bit 15. Bits not listed read 0, indices outside 6..21 read 0 and ignore writes, and cfg_rdata[31:16] always reads 0.
- R4: An enabled window matches when start <= txn_addr[31:20] <= end. Both bounds are inclusive.
- R5: A non-secure access (txn_ns=1) is denied when the deciding window has its secure flag set, and allowed when the flag is clear.
- R6: An access with txn_ns=0 is always allowed.
- R7: When several enabled windows match, the lowest-numbered one decides and its index appears on dec_rgn. With no match, dec_rgn is 8 and the catch-all secure flag decides.
- R8: While the pass-through switch is 1, every access is allowed. dec_rgn still reports the matching window.
- R9: dec_valid is 1 exactly in the cycle after txn_valid was 1. dec_allow and dec_rgn give that transaction's result in the same cycle.
- R10: A configuration write and a transaction in the same cycle: the transaction is judged against the configuration as it was before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 5 | Register index for write and read |
| cfg_wdata | input | 32 | Write data: [31:16] bit enables, [15:0] value |
| cfg_rdata | output | 32 | Read data of register cfg_idx (combinational) |
| txn_valid | input | 1 | Transaction address valid |
| txn_addr | input | 32 | Transaction byte address |
| txn_ns | input | 1 | 1 = non-secure master |
| dec_valid | output | 1 | Verdict valid |
| dec_allow | output | 1 | 1 = access allowed |
| dec_rgn | output | 4 | Deciding window, 8 = catch-all |

## Verification
A configuration write and a transaction lookup can land on the same clock edge. The bench provokes this by raising cfg_we, with a write that turns pass-through on, in the same cycle as txn_valid carrying a non-secure address inside a secure window. The verdict must still be a deny from the old configuration. A second lookup one cycle later must be allowed, which shows that the write did take effect.

// File: rtl/ddr_sec_pkg.sv
package ddr_sec_pkg;
   // control bit positions inside the 16-bit register payload
   localparam int unsigned CFG_PAY_W   = 16;
   localparam int unsigned BIT_EN      = 15;
   localparam int unsigned BIT_SEC     = 14;
   localparam int unsigned BIT_RGNX    = 13;
   localparam int unsigned BIT_BYPASS  = 15;
   localparam int unsigned MAX_MB_W    = 12;

   // payload bits that a register may hold
   function automatic logic [CFG_PAY_W-1:0] legal_bits(input int unsigned mb_w,
                                                       input bit is_start,
                                                       input bit is_last);
      logic [CFG_PAY_W-1:0] m;
      m = CFG_PAY_W'((32'd1 << mb_w) - 32'd1);
      if (is_start) begin
         m[BIT_EN]  = 1'b1;
         m[BIT_SEC] = 1'b1;
      end
      if (is_last) begin
         m[BIT_RGNX]   = 1'b1;
         m[BIT_BYPASS] = 1'b1;
      end
      return m;
   endfunction
endpackage

// File: rtl/dsf_regbank.sv
module dsf_regbank
   import ddr_sec_pkg::*;
#(
   parameter int unsigned NUM_RGN  = 8,
   parameter int unsigned MB_W     = 12,
   parameter int unsigned IDX_W    = 5,
   parameter int unsigned BASE_IDX = 6
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            we,
   input  logic [IDX_W-1:0]                idx,
   input  logic [31:0]                     wdata,
   output logic [31:0]                     rdata,
   output logic [NUM_RGN-1:0][MB_W-1:0]    rgn_lo,
   output logic [NUM_RGN-1:0][MB_W-1:0]    rgn_hi,
   output logic [NUM_RGN-1:0]              rgn_sec,
   output logic [NUM_RGN-1:0]              rgn_en,
   output logic                            rgnx_sec,
   output logic                            bypass
);
   localparam int unsigned NREG = 2 * NUM_RGN;

   logic [NREG-1:0][CFG_PAY_W-1:0] regs_q;
   logic [NREG-1:0]                hit_idx;
   logic [NREG-1:0][CFG_PAY_W-1:0] rd_terms;

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam bit IS_START = (i % 2) == 0;
      localparam bit IS_LAST  = (i == NREG - 1);
      localparam logic [CFG_PAY_W-1:0] LEGAL = legal_bits(MB_W, IS_START, IS_LAST);
      localparam logic [CFG_PAY_W-1:0] RST_V =
         IS_LAST ? CFG_PAY_W'(1 << BIT_BYPASS) : '0;

      assign hit_idx[i] = (idx == IDX_W'(BASE_IDX + i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs_q[i] <= RST_V;
         end else if (we && hit_idx[i]) begin
            regs_q[i] <= (regs_q[i] & ~(wdata[31:16] & LEGAL))
                       | (wdata[15:0] & wdata[31:16] & LEGAL);
         end
      end

      assign rd_terms[i] = hit_idx[i] ? regs_q[i] : '0;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NREG; i++) begin
         rdata[CFG_PAY_W-1:0] = rdata[CFG_PAY_W-1:0] | rd_terms[i];
      end
   end

   for (genvar n = 0; n < NUM_RGN; n++) begin : g_fld
      assign rgn_lo[n]  = regs_q[2*n][MB_W-1:0];
      assign rgn_hi[n]  = regs_q[2*n+1][MB_W-1:0];
      assign rgn_sec[n] = regs_q[2*n][BIT_SEC];
      assign rgn_en[n]  = regs_q[2*n][BIT_EN];
   end

   assign rgnx_sec = regs_q[NREG-1][BIT_RGNX];
   assign bypass   = regs_q[NREG-1][BIT_BYPASS];

   // R2: a write with no enable bits changes nothing
   a_r2_nomask_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wdata[31:16] == 16'h0) |=> $stable(regs_q));

   // R3: writes outside the window register range are ignored
   a_r3_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (we && hit_idx == '0) |=> $stable(regs_q));
endmodule

// File: rtl/dsf_rgn_cmp.sv
module dsf_rgn_cmp #(
   parameter int unsigned MB_W = 12
) (
   input  logic [MB_W-1:0] addr_mb,
   input  logic [MB_W-1:0] lo,
   input  logic [MB_W-1:0] hi,
   input  logic            en,
   output logic            hit
);
   logic above_lo;
   logic below_hi;

   assign above_lo = (addr_mb >= lo);
   assign below_hi = (addr_mb <= hi);
   assign hit      = en && above_lo && below_hi;
endmodule

// File: rtl/dsf_prio_pick.sv
module dsf_prio_pick #(
   parameter int unsigned N     = 8,
   parameter int unsigned IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     hits,
   output logic [N-1:0]     grant,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      grant = '0;
      idx   = IDX_W'(N);
      for (int i = N - 1; i >= 0; i--) begin
         if (hits[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            idx      = IDX_W'(i);
         end
      end
   end

   assign any = |hits;

   // R7: at most one window decides, and only a matching one
   a_r7_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & ~hits) == '0));

   // R7: any match yields a grant
   a_r7_grant_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> $countones(grant) == 1);
endmodule

// File: rtl/ddr_secure_filter.sv
module ddr_secure_filter
   import ddr_sec_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned MB_SHIFT  = 20,
   parameter int unsigned NUM_RGN   = 8,
   parameter int unsigned IDX_W     = 5,
   parameter int unsigned BASE_IDX  = 6,
   parameter int unsigned RGN_IDX_W = $clog2(NUM_RGN + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [IDX_W-1:0]      cfg_idx,
   input  logic [31:0]           cfg_wdata,
   output logic [31:0]           cfg_rdata,
   input  logic                  txn_valid,
   input  logic [ADDR_W-1:0]     txn_addr,
   input  logic                  txn_ns,
   output logic                  dec_valid,
   output logic                  dec_allow,
   output logic [RGN_IDX_W-1:0]  dec_rgn
);
   localparam int unsigned MB_W = ADDR_W - MB_SHIFT;

   if (MB_W < 1 || MB_W > MAX_MB_W) begin : g_bad_mbw
      $error("ddr_secure_filter: megabyte index width out of range");
   end
   if (NUM_RGN < 1) begin : g_bad_nrgn
      $error("ddr_secure_filter: at least one window required");
   end
   if (BASE_IDX + 2 * NUM_RGN > (1 << IDX_W)) begin : g_bad_idx
      $error("ddr_secure_filter: register index width too small");
   end
   if (RGN_IDX_W < $clog2(NUM_RGN + 1)) begin : g_bad_rgnw
      $error("ddr_secure_filter: window index width too small");
   end

   logic [NUM_RGN-1:0][MB_W-1:0] rgn_lo;
   logic [NUM_RGN-1:0][MB_W-1:0] rgn_hi;
   logic [NUM_RGN-1:0]           rgn_sec;
   logic [NUM_RGN-1:0]           rgn_en;
   logic                         rgnx_sec;
   logic                         bypass;
   logic [MB_W-1:0]              addr_mb;
   logic [NUM_RGN-1:0]           hits;
   logic [NUM_RGN-1:0]           grant;
   logic                         hit_any;
   logic [RGN_IDX_W-1:0]         pick_idx;
   logic                         sec_target;
   logic                         allow_d;
   logic                         unused_addr_lo;

   assign addr_mb        = txn_addr[ADDR_W-1:MB_SHIFT];
   assign unused_addr_lo = ^txn_addr[MB_SHIFT-1:0];

   dsf_regbank #(
      .NUM_RGN  (NUM_RGN),
      .MB_W     (MB_W),
      .IDX_W    (IDX_W),
      .BASE_IDX (BASE_IDX)
   ) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (cfg_we),
      .idx      (cfg_idx),
      .wdata    (cfg_wdata),
      .rdata    (cfg_rdata),
      .rgn_lo   (rgn_lo),
      .rgn_hi   (rgn_hi),
      .rgn_sec  (rgn_sec),
      .rgn_en   (rgn_en),
      .rgnx_sec (rgnx_sec),
      .bypass   (bypass)
   );

   for (genvar n = 0; n < NUM_RGN; n++) begin : g_cmp
      dsf_rgn_cmp #(.MB_W(MB_W)) i_cmp (
         .addr_mb (addr_mb),
         .lo      (rgn_lo[n]),
         .hi      (rgn_hi[n]),
         .en      (rgn_en[n]),
         .hit     (hits[n])
      );
   end

   dsf_prio_pick #(.N(NUM_RGN), .IDX_W(RGN_IDX_W)) i_pick (
      .clk   (clk),
      .rst_n (rst_n),
      .hits  (hits),
      .grant (grant),
      .any   (hit_any),
      .idx   (pick_idx)
   );

   assign sec_target = hit_any ? |(grant & rgn_sec) : rgnx_sec;
   assign allow_d    = bypass || !txn_ns || !sec_target;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         dec_allow <= 1'b0;
         dec_rgn   <= '0;
      end else begin
         dec_valid <= txn_valid;
         if (txn_valid) begin
            dec_allow <= allow_d;
            dec_rgn   <= pick_idx;
         end
      end
   end

   // R8: pass-through allows everything
   a_r8_bypass_allows: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && bypass) |=> dec_allow);

   // R6: secure masters always pass
   a_r6_secure_allowed: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && !txn_ns) |=> dec_allow);

   // R9: verdict strobe one cycle after the request
   a_r9_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |=> dec_valid);
   a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !txn_valid |=> !dec_valid);

   // R7: no match reports the catch-all index
   a_r7_catch_index: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && !hit_any) |=> dec_rgn == RGN_IDX_W'(NUM_RGN));

   // R5: a non-secure hit on a secure enabled window is refused
   a_r5_ns_denied: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && txn_ns && !bypass && hit_any && |(grant & rgn_sec)) |=> !dec_allow);
endmodule

// File: tb/test_ddr_secure_filter.sv
module test_ddr_secure_filter;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [4:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        txn_valid = 1'b0;
   logic [31:0] txn_addr = '0;
   logic        txn_ns = 1'b0;
   logic        dec_valid;
   logic        dec_allow;
   logic [3:0]  dec_rgn;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   ddr_secure_filter i_ddr_secure_filter (
      .clk, .rst_n, .cfg_we, .cfg_idx, .cfg_wdata, .cfg_rdata,
      .txn_valid, .txn_addr, .txn_ns, .dec_valid, .dec_allow, .dec_rgn
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] idx, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd_check(input string req, input logic [4:0] idx, input logic [31:0] exp);
      cfg_idx = idx;
      #1;
      check(req, cfg_rdata, exp);
   endtask

   task automatic look(input string req, input logic [31:0] a, input logic ns,
                       input logic exp_allow, input logic [3:0] exp_rgn);
      @(negedge clk);
      txn_valid = 1'b1; txn_addr = a; txn_ns = ns;
      @(negedge clk);
      txn_valid = 1'b0;
      check({req, " valid"}, 32'(dec_valid), 32'd1);
      check({req, " allow"}, 32'(dec_allow), 32'(exp_allow));
      check({req, " rgn"},   32'(dec_rgn),   32'(exp_rgn));
   endtask

   task automatic t_reset;
      for (int i = 0; i < 32; i++) begin
         rd_check("R1 reset readback", 5'(i), (i == 21) ? 32'h0000_8000 : 32'h0);
      end
      check("R1 reset dec_valid", 32'(dec_valid), 32'd0);
      check("R1 reset dec_allow", 32'(dec_allow), 32'd0);
      check("R1 reset dec_rgn",   32'(dec_rgn),   32'd0);
   endtask

   task automatic t_masked_writes;
      wr(5'd6, 32'h0FFF_0123);
      rd_check("R2 full field write", 5'd6, 32'h0000_0123);
      wr(5'd6, 32'h00FF_FFFF);
      rd_check("R2 low byte only", 5'd6, 32'h0000_01FF);
      wr(5'd6, 32'h0000_FFFF);
      rd_check("R2 zero mask", 5'd6, 32'h0000_01FF);
      wr(5'd3, 32'hFFFF_FFFF);
      rd_check("R3 index outside range", 5'd3, 32'h0);
      wr(5'd7, 32'hFFFF_FFFF);
      rd_check("R3 end register fields", 5'd7, 32'h0000_0FFF);
      wr(5'd21, 32'hFFFF_FFFF);
      rd_check("R3 last register fields", 5'd21, 32'h0000_AFFF);
      wr(5'd6, 32'hFFFF_0000);
      wr(5'd7, 32'hFFFF_0000);
      wr(5'd21, 32'h7FFF_0000);
      rd_check("R2 keep pass-through bit", 5'd21, 32'h0000_8000);
      rd_check("R3 cleared start", 5'd6, 32'h0);
   endtask

   task automatic t_single_window;
      wr(5'd6, 32'h0FFF_0000);
      wr(5'd7, 32'h0FFF_001F);
      wr(5'd6, 32'h4000_4000);
      wr(5'd6, 32'h8000_8000);
      rd_check("R3 start with flags", 5'd6, 32'h0000_C000);
      rd_check("R3 end value", 5'd7, 32'h0000_001F);
      look("R8 pass-through", 32'h0000_0000, 1'b1, 1'b1, 4'd0);
      wr(5'd21, 32'h8000_0000);
      rd_check("R3 pass-through off", 5'd21, 32'h0);
      look("R4 R5 inclusive end deny", 32'h01F0_0000, 1'b1, 1'b0, 4'd0);
      look("R4 last byte of window", 32'h01FF_FFFF, 1'b1, 1'b0, 4'd0);
      look("R4 just past end", 32'h0200_0000, 1'b1, 1'b1, 4'd8);
      look("R6 secure master", 32'h0000_1000, 1'b0, 1'b1, 4'd0);
   endtask

   task automatic t_priority;
      wr(5'd10, 32'h0FFF_0010);
      wr(5'd11, 32'h0FFF_003F);
      wr(5'd10, 32'h8000_8000);
      wr(5'd8,  32'h0FFF_0028);
      wr(5'd9,  32'h0FFF_0032);
      wr(5'd8,  32'hC000_C000);
      look("R7 window 0 over 2", 32'h0140_0000, 1'b1, 1'b0, 4'd0);
      look("R7 window 1 over 2", 32'h02D0_0000, 1'b1, 1'b0, 4'd1);
      look("R5 non-secure window allows", 32'h0370_0000, 1'b1, 1'b1, 4'd2);
      wr(5'd20, 32'h0FFF_0100);
      wr(5'd21, 32'h0FFF_01FF);
      wr(5'd20, 32'hC000_C000);
      look("R7 top window", 32'h1800_0000, 1'b1, 1'b0, 4'd7);
      wr(5'd12, 32'h4FFF_4400);
      wr(5'd13, 32'h0FFF_0400);
      look("R4 disabled window ignored", 32'h4000_0000, 1'b1, 1'b1, 4'd8);
      wr(5'd21, 32'h2000_2000);
      rd_check("R3 catch-all flag", 5'd21, 32'h0000_21FF);
      look("R7 catch-all secure deny", 32'h4000_0000, 1'b1, 1'b0, 4'd8);
      look("R6 catch-all secure master", 32'h4000_0000, 1'b0, 1'b1, 4'd8);
   endtask

   task automatic t_collision;
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 5'd21; cfg_wdata = 32'h8000_8000;
      txn_valid = 1'b1; txn_addr = 32'h0140_0000; txn_ns = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0; txn_valid = 1'b0;
      check("R10 old config deny", 32'(dec_allow), 32'd0);
      check("R10 old config rgn",  32'(dec_rgn),   32'd0);
      look("R10 new config allow", 32'h0140_0000, 1'b1, 1'b1, 4'd0);
      @(negedge clk);
      check("R9 valid drops", 32'(dec_valid), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_masked_writes();
      t_single_window();
      t_priority();
      t_collision();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule